// File: doc/BRIEF.md
# Prioritised Interrupt Source Controller

This block gathers interrupt requests from up to 128 sources and hands the processor core one winning request at a time. Each source is named by a 12-bit event code. The code space is split into 32-code steps, so the slot index is the code divided by 0x20. Every slot holds an asserted flag. Each slot also has a 4-bit priority level, which is worked out from packed nibble fields in a small set of memory-mapped priority registers. The fifteen external request lines are the exception: their levels are fixed. A slot whose level is zero counts as unimplemented, and it never wins.

Sources are raised and dropped one at a time through an event port. When a source is raised, it takes the selection if nothing is selected or if its level is strictly higher than the current one. When an asserted source is dropped, or when a priority register is written, the controller rescans every slot. The rescan keeps the highest level, and among equal levels the lowest slot index wins. So the result on a tie depends on whether it came from an incremental raise or from a full rescan. The outputs are registered and change on the clock edge that takes the event or the write.

Top module: `intc_prio_top`

## Requirements
- R1: After reset the registers read as follows: word 0x0C reads 0x0000DA74, word 0x10 reads 0xF3FF7FFF, word 0x14 reads 0x00FFFFFF, and words 0x20, 0x24, 0x28 and 0x2C read 0x33333333. Words 0x00, 0x04 and 0x08 read zero, and irq_valid is 0.
- R2: Words 0x00 to 0x0C are 16-bit registers whose bits 31:16 read zero. Word 0x00 bits 3:0 always read zero. Words 0x10 to 0x2C store all 32 bits. A write to any other address changes no register and reads back zero.
- R3: Slot levels are set as follows:
  - External line n (0 to 14) sits at code 0x200 + n*0x20 and has a fixed level of 15-n.
  - The timer sources at codes 0x400, 0x420 and 0x440 take their levels from word 0x00 bits 15:12, 11:8 and 7:4.
  - The serial sources at codes 0x700 to 0x760 take their level from word 0x28 bits 19:16.
  - Every other slot has level 0.
- R4: A source whose current level is 0 is never presented, even while asserted.
- R5: Raising a source (evt_valid=1, evt_assert=1) selects it when nothing is selected or when its level is strictly greater than irq_level. Otherwise, including the case of an equal level, the selection is unchanged.
- R6: Dropping an asserted source (evt_valid=1, evt_assert=0) clears its flag and rescans all slots. The rescan presents the highest level, and the lowest index among equal levels.
- R7: Dropping a source that is not asserted has no effect on the outputs.
- R8: A write to a priority register (words 0x00 to 0x0C and 0x20 to 0x2C) recomputes all levels and rescans as in R6, and leaves every asserted flag unchanged. A write to words 0x10 or 0x14 triggers no rescan.
- R9: irq_code equals the slot index times 0x20, and irq_level equals that slot's level. Both read zero when irq_valid is 0. The outputs change only on the edge that takes an event or a priority write, and they hold otherwise.
- R10: Bits 4:0 of evt_code are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_valid | input | 1 | An event is offered this cycle |
| evt_assert | input | 1 | 1 raises the source, 0 drops it |
| evt_code | input | 12 | Event code of the source |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address (word aligned) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq_valid | output | 1 | A request is presented |
| irq_code | output | 12 | Event code of the presented request |
| irq_level | output | 4 | Level of the presented request |

## Verification
The assertions check the following on every cycle:
- A presented request never has level zero, and its slot flag is still set.
- The presented level matches the level map whenever no write is pending.
- A strictly higher raise always takes over, and an equal or lower raise changes nothing.
- A priority write never disturbs the flags.
- The outputs hold while the block is idle.

Some behaviours only the bench scenarios can show. One is the tie split between the incremental raise path and the rescan, where the same two sources give different winners. Others are the exact reset and read-back values of the registers and the effect of rewriting a level field on sources that are already asserted.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 6;
  localparam int LVL_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_PRI_A = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PRI_B = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_PRI_C = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_PRI_D = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_MSK_0 = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_MSK_1 = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_GRP_0 = 6'h20;

  localparam int GRP_COUNT = 4;

  localparam logic [15:0]      RST_PRI_D = 16'hDA74;
  localparam logic [REG_W-1:0] RST_MSK_0 = 32'hF3FF_7FFF;
  localparam logic [REG_W-1:0] RST_MSK_1 = 32'h00FF_FFFF;
  localparam logic [REG_W-1:0] RST_GRP   = 32'h3333_3333;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      rst_q_n  <= stage1_q;
    end
  end
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int SER_LSB  = 16,
  parameter int SER_GRP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              prio_wr,
  output logic [11:0]       tmr_fields_nx,
  output logic [LVL_W-1:0]  ser_level_nx
);
  logic [15:4]      pri_a_q, pri_a_nx;
  logic [15:0]      pri_b_q, pri_b_nx;
  logic [15:0]      pri_c_q, pri_c_nx;
  logic [15:0]      pri_d_q, pri_d_nx;
  logic [REG_W-1:0] msk0_q, msk0_nx;
  logic [REG_W-1:0] msk1_q, msk1_nx;
  logic [REG_W-1:0] grp_q  [GRP_COUNT];
  logic [REG_W-1:0] grp_nx [GRP_COUNT];
  logic             grp_hit;

  // next-state
  always_comb begin
    pri_a_nx = pri_a_q;
    pri_b_nx = pri_b_q;
    pri_c_nx = pri_c_q;
    pri_d_nx = pri_d_q;
    msk0_nx  = msk0_q;
    msk1_nx  = msk1_q;
    grp_hit  = 1'b0;
    for (int k = 0; k < GRP_COUNT; k++) begin
      grp_nx[k] = grp_q[k];
      if (wr_en && addr == OFS_GRP_0 + ADDR_W'(4 * k)) begin
        grp_nx[k] = wdata;
        grp_hit   = 1'b1;
      end
    end
    if (wr_en) begin
      case (addr)
        OFS_PRI_A: pri_a_nx = wdata[15:4];
        OFS_PRI_B: pri_b_nx = wdata[15:0];
        OFS_PRI_C: pri_c_nx = wdata[15:0];
        OFS_PRI_D: pri_d_nx = wdata[15:0];
        OFS_MSK_0: msk0_nx  = wdata;
        OFS_MSK_1: msk1_nx  = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    prio_wr = 1'b0;
    if (wr_en) begin
      case (addr)
        OFS_PRI_A, OFS_PRI_B, OFS_PRI_C, OFS_PRI_D: prio_wr = 1'b1;
        default: prio_wr = grp_hit;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_a_q <= '0;
      pri_b_q <= '0;
      pri_c_q <= '0;
      pri_d_q <= RST_PRI_D;
      msk0_q  <= RST_MSK_0;
      msk1_q  <= RST_MSK_1;
    end else if (wr_en) begin
      pri_a_q <= pri_a_nx;
      pri_b_q <= pri_b_nx;
      pri_c_q <= pri_c_nx;
      pri_d_q <= pri_d_nx;
      msk0_q  <= msk0_nx;
      msk1_q  <= msk1_nx;
    end
  end

  for (genvar k = 0; k < GRP_COUNT; k++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      grp_q[k] <= RST_GRP;
      else if (wr_en)  grp_q[k] <= grp_nx[k];
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_PRI_A: rdata = {16'h0, pri_a_q, 4'h0};
      OFS_PRI_B: rdata = {16'h0, pri_b_q};
      OFS_PRI_C: rdata = {16'h0, pri_c_q};
      OFS_PRI_D: rdata = {16'h0, pri_d_q};
      OFS_MSK_0: rdata = msk0_q;
      OFS_MSK_1: rdata = msk1_q;
      default: begin
        for (int k = 0; k < GRP_COUNT; k++)
          if (addr == OFS_GRP_0 + ADDR_W'(4 * k)) rdata = grp_q[k];
      end
    endcase
  end

  assign tmr_fields_nx = pri_a_nx;
  assign ser_level_nx  = grp_nx[SER_GRP][SER_LSB +: LVL_W];
endmodule

// File: rtl/intc_level_map.sv
module intc_level_map
  import intc_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  parameter int IRQ_BASE  = 16,
  parameter int IRQ_COUNT = 15,
  parameter int TMR_BASE  = 32,
  parameter int SER_FIRST = 56,
  parameter int SER_LAST  = 59
) (
  input  logic [11:0]                      tmr_fields,
  input  logic [LVL_W-1:0]                 ser_level,
  output logic [NUM_SLOTS-1:0][LVL_W-1:0]  slot_lvl
);
  localparam int TMR_COUNT = 3;
  localparam int LVL_MAX   = (1 << LVL_W) - 1;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s >= IRQ_BASE && s < IRQ_BASE + IRQ_COUNT) begin : g_irq
      assign slot_lvl[s] = LVL_W'(LVL_MAX - (s - IRQ_BASE));
    end else if (s >= TMR_BASE && s < TMR_BASE + TMR_COUNT) begin : g_tmr
      assign slot_lvl[s] = tmr_fields[11 - LVL_W * (s - TMR_BASE) -: LVL_W];
    end else if (s >= SER_FIRST && s <= SER_LAST) begin : g_ser
      assign slot_lvl[s] = ser_level;
    end else begin : g_none
      assign slot_lvl[s] = '0;
    end
  end
endmodule

// File: rtl/intc_scan_tree.sv
module intc_scan_tree
  import intc_pkg::*;
#(
  parameter int IDX_W = 7,
  localparam int NUM  = 1 << IDX_W
) (
  input  logic [NUM-1:0][LVL_W-1:0] cand_lvl,
  output logic                      win_vld,
  output logic [IDX_W-1:0]          win_idx,
  output logic [LVL_W-1:0]          win_lvl
);
  for (genvar st = 0; st <= IDX_W; st++) begin : g_stage
    localparam int W = NUM >> st;
    logic [LVL_W-1:0] s_lvl [W];
    logic [IDX_W-1:0] s_idx [W];
    if (st == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_l
        assign s_lvl[i] = cand_lvl[i];
        assign s_idx[i] = IDX_W'(i);
      end
    end else begin : g_node
      for (genvar i = 0; i < W; i++) begin : g_n
        logic take_hi;
        // upper half wins only when strictly greater: lower index keeps ties
        assign take_hi  = g_stage[st-1].s_lvl[2*i+1] > g_stage[st-1].s_lvl[2*i];
        assign s_lvl[i] = take_hi ? g_stage[st-1].s_lvl[2*i+1] : g_stage[st-1].s_lvl[2*i];
        assign s_idx[i] = take_hi ? g_stage[st-1].s_idx[2*i+1] : g_stage[st-1].s_idx[2*i];
      end
    end
  end

  assign win_lvl = g_stage[IDX_W].s_lvl[0];
  assign win_vld = (win_lvl != '0);
  assign win_idx = win_vld ? g_stage[IDX_W].s_idx[0] : '0;
endmodule

// File: rtl/intc_prio_top.sv
module intc_prio_top
  import intc_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int STEP_W    = 5,
  parameter int IRQ_BASE  = 16,
  parameter int IRQ_COUNT = 15,
  parameter int TMR_BASE  = 32,
  parameter int SER_FIRST = 56,
  parameter int SER_LAST  = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_assert,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_valid,
  output logic [CODE_W-1:0] irq_code,
  output logic [LVL_W-1:0]  irq_level
);
  localparam int IDX_W     = CODE_W - STEP_W;
  localparam int NUM_SLOTS = 1 << IDX_W;

  logic                             rst_q_n;
  logic                             prio_wr;
  logic [11:0]                      tmr_fields_nx;
  logic [LVL_W-1:0]                 ser_level_nx;
  logic [NUM_SLOTS-1:0][LVL_W-1:0]  slot_lvl;
  logic [NUM_SLOTS-1:0][LVL_W-1:0]  cand_lvl;
  logic [NUM_SLOTS-1:0]             flag_q, flag_nx;
  logic [IDX_W-1:0]                 evt_idx;
  logic [STEP_W-1:0]                evt_unused_lsb;
  logic [LVL_W-1:0]                 evt_lvl;
  logic                             win_vld;
  logic [IDX_W-1:0]                 win_idx;
  logic [LVL_W-1:0]                 win_lvl;
  logic                             rescan, take_new, flag_en, sel_en;
  logic                             sel_vld_q, sel_vld_nx;
  logic [IDX_W-1:0]                 sel_idx_q, sel_idx_nx;
  logic [LVL_W-1:0]                 sel_lvl_q, sel_lvl_nx;

  intc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  intc_regfile u_regs (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .wr_en         (bus_wr_en),
    .addr          (bus_addr),
    .wdata         (bus_wdata),
    .rdata         (bus_rdata),
    .prio_wr       (prio_wr),
    .tmr_fields_nx (tmr_fields_nx),
    .ser_level_nx  (ser_level_nx)
  );

  // levels follow the register values being written this cycle
  intc_level_map #(
    .NUM_SLOTS (NUM_SLOTS),
    .IRQ_BASE  (IRQ_BASE),
    .IRQ_COUNT (IRQ_COUNT),
    .TMR_BASE  (TMR_BASE),
    .SER_FIRST (SER_FIRST),
    .SER_LAST  (SER_LAST)
  ) u_map (
    .tmr_fields (tmr_fields_nx),
    .ser_level  (ser_level_nx),
    .slot_lvl   (slot_lvl)
  );

  assign evt_idx        = evt_code[CODE_W-1:STEP_W];
  assign evt_unused_lsb = evt_code[STEP_W-1:0];
  assign evt_lvl        = slot_lvl[evt_idx];

  // slot flags: next-state
  always_comb begin
    flag_nx = flag_q;
    if (evt_valid) flag_nx[evt_idx] = evt_assert;
  end
  assign flag_en = evt_valid;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cand
    assign cand_lvl[s] = flag_nx[s] ? slot_lvl[s] : '0;
  end

  intc_scan_tree #(.IDX_W(IDX_W)) u_scan (
    .cand_lvl (cand_lvl),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  // selection: next-state
  always_comb begin
    rescan   = prio_wr || (evt_valid && !evt_assert && flag_q[evt_idx]);
    take_new = evt_valid && evt_assert && (evt_lvl != '0) &&
               (!sel_vld_q || evt_lvl > sel_lvl_q);
    sel_en   = rescan || take_new;
    if (rescan) begin
      sel_vld_nx = win_vld;
      sel_idx_nx = win_idx;
      sel_lvl_nx = win_lvl;
    end else if (take_new) begin
      sel_vld_nx = 1'b1;
      sel_idx_nx = evt_idx;
      sel_lvl_nx = evt_lvl;
    end else begin
      sel_vld_nx = sel_vld_q;
      sel_idx_nx = sel_idx_q;
      sel_lvl_nx = sel_lvl_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     flag_q <= '0;
    else if (flag_en) flag_q <= flag_nx;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sel_vld_q <= 1'b0;
      sel_idx_q <= '0;
      sel_lvl_q <= '0;
    end else if (sel_en) begin
      sel_vld_q <= sel_vld_nx;
      sel_idx_q <= sel_idx_nx;
      sel_lvl_q <= sel_lvl_nx;
    end
  end

  assign irq_valid = sel_vld_q;
  assign irq_code  = {sel_idx_q, {STEP_W{1'b0}}};
  assign irq_level = sel_lvl_q;
endmodule

// File: rtl/intc_prio_checker.sv
module intc_prio_checker
  import intc_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int STEP_W = 5,
  localparam int IDX_W = CODE_W - STEP_W,
  localparam int NUM_SLOTS = 1 << IDX_W
) (
  input logic                            clk,
  input logic                            rst_q_n,
  input logic                            evt_valid,
  input logic                            evt_assert,
  input logic [CODE_W-1:0]               evt_code,
  input logic                            prio_wr,
  input logic [NUM_SLOTS-1:0]            flag_q,
  input logic [NUM_SLOTS-1:0][LVL_W-1:0] slot_lvl,
  input logic                            irq_valid,
  input logic [CODE_W-1:0]               irq_code,
  input logic [LVL_W-1:0]                irq_level
);
  logic [IDX_W-1:0]  evt_idx, win_idx;
  logic [STEP_W-1:0] chk_unused_lsb;
  logic [LVL_W-1:0]  evt_lvl;

  assign evt_idx        = evt_code[CODE_W-1:STEP_W];
  assign win_idx        = irq_code[CODE_W-1:STEP_W];
  assign chk_unused_lsb = evt_code[STEP_W-1:0];
  assign evt_lvl        = slot_lvl[evt_idx];

  assert_level_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_valid |-> irq_level != '0);

  assert_winner_flagged_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_valid |-> flag_q[win_idx]);

  assert_level_from_map_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_valid && !prio_wr) |-> irq_level == slot_lvl[win_idx]);

  assert_higher_takes_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (evt_valid && evt_assert && !prio_wr && evt_lvl != '0 &&
     (!irq_valid || evt_lvl > irq_level))
    |=> (irq_valid && irq_code[CODE_W-1:STEP_W] == $past(evt_idx) &&
         irq_level == $past(evt_lvl)));

  assert_equal_keeps_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (evt_valid && evt_assert && !prio_wr && irq_valid && evt_lvl <= irq_level)
    |=> $stable({irq_valid, irq_code, irq_level}));

  assert_flags_kept_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (prio_wr && !evt_valid) |=> $stable(flag_q));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!evt_valid && !prio_wr) |=> $stable({irq_valid, irq_code, irq_level}));
endmodule

bind intc_prio_top intc_prio_checker #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .evt_valid  (evt_valid),
  .evt_assert (evt_assert),
  .evt_code   (evt_code),
  .prio_wr    (prio_wr),
  .flag_q     (flag_q),
  .slot_lvl   (slot_lvl),
  .irq_valid  (irq_valid),
  .irq_code   (irq_code),
  .irq_level  (irq_level)
);

// File: tb/intc_prio_top_test.sv
`timescale 1ns/1ps
module intc_prio_top_test;
  logic        clk;
  logic        rst_n;
  logic        evt_valid, evt_assert;
  logic [11:0] evt_code;
  logic        bus_wr_en;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_valid;
  logic [11:0] irq_code;
  logic [3:0]  irq_level;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  intc_prio_top uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_assert(evt_assert),
    .evt_code(evt_code), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_valid(irq_valid),
    .irq_code(irq_code), .irq_level(irq_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // row: op(2) | code or address(12) | data(32) | exp valid(1) | exp code(12) | exp level(4) | req(4)
  // op 0 raise, 1 drop, 2 register write
  localparam int ROWS = 20;
  localparam logic [66:0] TBL [ROWS] = '{
    {2'd0, 12'h700, 32'h0,         1'b1, 12'h700, 4'd3,  4'd5},  // R5 first raise
    {2'd0, 12'h760, 32'h0,         1'b1, 12'h700, 4'd3,  4'd5},  // R5 equal level keeps
    {2'd0, 12'h400, 32'h0,         1'b1, 12'h700, 4'd3,  4'd4},  // R4 level-0 timer
    {2'd2, 12'h000, 32'h0000_5670, 1'b1, 12'h400, 4'd5,  4'd8},  // R8 level rewrite
    {2'd0, 12'h3C0, 32'h0,         1'b1, 12'h400, 4'd5,  4'd5},  // R5 lower keeps
    {2'd0, 12'h220, 32'h0,         1'b1, 12'h220, 4'd14, 4'd3},  // R3 line 1 = 14
    {2'd1, 12'h220, 32'h0,         1'b1, 12'h400, 4'd5,  4'd6},  // R6 rescan
    {2'd1, 12'h400, 32'h0,         1'b1, 12'h700, 4'd3,  4'd6},  // R6 tie lowest
    {2'd1, 12'h700, 32'h0,         1'b1, 12'h760, 4'd3,  4'd6},  // R6
    {2'd1, 12'h700, 32'h0,         1'b1, 12'h760, 4'd3,  4'd7},  // R7 not asserted
    {2'd2, 12'h028, 32'h0,         1'b1, 12'h3C0, 4'd1,  4'd8},  // R8 serial to 0
    {2'd2, 12'h028, 32'h0009_0000, 1'b1, 12'h760, 4'd9,  4'd8},  // R8 serial to 9
    {2'd0, 12'h71F, 32'h0,         1'b1, 12'h760, 4'd9,  4'd10}, // R10 low bits
    {2'd2, 12'h010, 32'h0,         1'b1, 12'h760, 4'd9,  4'd8},  // R8 mask, no rescan
    {2'd2, 12'h028, 32'h0009_0000, 1'b1, 12'h700, 4'd9,  4'd8},  // R8 rescan tie
    {2'd1, 12'h700, 32'h0,         1'b1, 12'h760, 4'd9,  4'd6},  // R6
    {2'd1, 12'h760, 32'h0,         1'b1, 12'h3C0, 4'd1,  4'd6},  // R6
    {2'd1, 12'h3C0, 32'h0,         1'b0, 12'h000, 4'd0,  4'd9},  // R9 empty reads 0
    {2'd0, 12'h000, 32'h0,         1'b0, 12'h000, 4'd0,  4'd4},  // R4 unimplemented
    {2'd1, 12'h000, 32'h0,         1'b0, 12'h000, 4'd0,  4'd7}   // R7 / R6 empty
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic v, input logic [11:0] c,
                         input logic [3:0] l);
    chk(req, {31'h0, irq_valid}, {31'h0, v});
    chk(req, {20'h0, irq_code}, {20'h0, c});
    chk(req, {28'h0, irq_level}, {28'h0, l});
  endtask

  task automatic evt(input logic kind, input logic [11:0] code);
    @(negedge clk);
    evt_valid = 1'b1; evt_assert = kind; evt_code = code;
    @(negedge clk);
    evt_valid = 1'b0; evt_assert = 1'b0; evt_code = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; evt_valid = 1'b0; evt_assert = 1'b0; evt_code = '0;
    bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_out("R1 reset outputs", 1'b0, 12'h0, 4'h0);
    rd(6'h00, rv); chk("R1 word 0x00", rv, 32'h0);
    rd(6'h04, rv); chk("R1 word 0x04", rv, 32'h0);
    rd(6'h08, rv); chk("R1 word 0x08", rv, 32'h0);
    rd(6'h0C, rv); chk("R1 word 0x0C", rv, 32'h0000_DA74);
    rd(6'h10, rv); chk("R1 word 0x10", rv, 32'hF3FF_7FFF);
    rd(6'h14, rv); chk("R1 word 0x14", rv, 32'h00FF_FFFF);
    for (int k = 0; k < 4; k++) begin
      rd(6'(6'h20 + 4 * k), rv); chk("R1 level group", rv, 32'h3333_3333);
    end

    // vector table
    for (int i = 0; i < ROWS; i++) begin
      logic [66:0] row;
      string tag;
      row = TBL[i];
      tag = $sformatf("R%0d row %0d", row[3:0], i);
      case (row[66:65])
        2'd0: evt(1'b1, row[64:53]);
        2'd1: evt(1'b0, row[64:53]);
        default: wr(row[58:53], row[52:21]);
      endcase
      chk_out(tag, row[20], row[19:8], row[7:4]);
    end

    // R3 timer 1 from word 0x00 bits 11:8 (currently 6)
    evt(1'b1, 12'h420); chk_out("R3 timer1 level", 1'b1, 12'h420, 4'd6);
    evt(1'b0, 12'h420); chk_out("R6 empty after drop", 1'b0, 12'h0, 4'd0);
    // R3 line 0 is level 15
    evt(1'b1, 12'h200); chk_out("R3 line0 level", 1'b1, 12'h200, 4'd15);
    // R9 idle hold
    repeat (3) @(negedge clk);
    chk_out("R9 idle hold", 1'b1, 12'h200, 4'd15);
    evt(1'b0, 12'h200); chk_out("R6 drop line0", 1'b0, 12'h0, 4'd0);

    // R2 register field widths and unmapped addresses
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, rv); chk("R2 word 0x00 reserved nibble", rv, 32'h0000_FFF0);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, rv); chk("R2 16-bit register", rv, 32'h0000_FFFF);
    wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, rv); chk("R2 unmapped reads zero", rv, 32'h0);
    rd(6'h14, rv); chk("R2 unmapped write no effect", rv, 32'h00FF_FFFF);
    wr(6'h2C, 32'hA5A5_5A5A); rd(6'h2C, rv); chk("R2 32-bit register", rv, 32'hA5A5_5A5A);
    // R3 timer 2 after word 0x00 = all ones
    evt(1'b1, 12'h440); chk_out("R3 timer2 level", 1'b1, 12'h440, 4'd15);
    evt(1'b0, 12'h440);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule